// File: doc/BRIEF.md
# Flash Erase and Program Job Sequencer

This controller sits on the host side of a byte-wide parallel flash device. It drives the bus signals itself: chip select, write strobe, read strobe, address, and a data byte with a separate output-enable. A single start pulse runs one job, either erasing one block or writing one byte. The sequencer sends the two-cycle command for the job. It then reads the flash status byte repeatedly until the device reports ready. It grades the final status into a result code. On any error it sends a clear-status command. It always finishes by returning the flash to array-read mode.

Each bus cycle uses a strobe whose width in clock cycles is set by a parameter. A recovery gap, also set by a parameter, follows every strobe. Address and data stay valid through the strobe's rising edge and through the gap after it. Every status read is a fresh strobe with a high-then-low transition, so the device re-captures its status on each poll. A cycle counter limits the time spent polling. A busy device that never reports ready ends the job with a timeout result.

Top module: `flash_job_sequencer`

## Requirements
- R1: While reset is held and on the first cycle after it, `fl_ce_n_o`, `fl_we_n_o` and `fl_oe_n_o` are 1, and `busy_o`, `done_o` and `result_o` are 0.
- R2: For an erase (`job_erase_i`=1), the first two bus writes are 20h and then D0h, both at `addr_i`. For a byte program (`job_erase_i`=0), the first write is 40h at `addr_i` and the second is `data_i` at `addr_i`.
- R3: The write strobe and the read strobe are never low together. The chip select is low whenever either strobe is low. Each strobe stays low for exactly STB_W cycles. At least REC_W cycles with both strobes high come before every new strobe.
- R4: When the write strobe rises, address and write data are unchanged from the previous cycle, and the data bus is being driven.
- R5: After the second command write, the sequencer issues read cycles until a read returns status bit 7 = 1. A read with bit 7 = 0 is followed by another read.
- R6: The final status sets the result code by this priority. Bit 3 gives 1 (voltage). Otherwise bit 1 gives 2 (lock). Otherwise bits 4 and 5 both set give 3 (sequence). Otherwise bit 5 gives 4 (failure) for an erase, and bit 4 gives 4 for a program. Anything else gives 0. Bit 4 alone in an erase and bit 5 alone in a program give 0.
- R7: When the result is non-zero, the sequencer writes 50h at `addr_i` after polling and before the final write. When the result is 0, it writes no 50h.
- R8: The last write of every job is FFh at `addr_i`. After that write, `done_o` is high for exactly one cycle with `busy_o` low. `result_o` holds the code from then until the next job.
- R9: If bit 7 has not been seen after TIMEOUT cycles of polling, the job ends with result 5, followed by a 50h write and then an FFh write.
- R10: A start pulse while `busy_o` is high is ignored and adds no bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Job start pulse, taken only while idle |
| job_erase_i | input | 1 | 1 = block erase, 0 = byte program |
| addr_i | input | ADDR_W | Target address (any address inside the block for an erase) |
| data_i | input | 8 | Byte to program |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle job completion pulse |
| result_o | output | 3 | Result code: 0 ok, 1 voltage, 2 lock, 3 sequence, 4 failure, 5 timeout |
| fl_ce_n_o | output | 1 | Flash chip select, active low |
| fl_we_n_o | output | 1 | Flash write strobe, active low |
| fl_oe_n_o | output | 1 | Flash read strobe, active low |
| fl_addr_o | output | ADDR_W | Flash address |
| fl_dq_o | output | 8 | Data driven to the flash |
| fl_dq_oe_o | output | 1 | 1 while the sequencer drives the data bus |
| fl_dq_i | input | 8 | Data read from the flash |

## Verification
The assertions check the bus-timing rules on every cycle. These are strobe exclusivity, chip select tracking the strobes, exact strobe width, minimum recovery gap, address and data held through the write-strobe rising edge, and the single-cycle done pulse with its result range. Only the bench scenarios can show the order of command bytes and their addresses. The same holds for the grading of each status pattern by priority, whether the clear-status write appears, the timeout outcome, and a start ignored mid-job. The bench does this by replaying jobs against a behavioural flash model with injected status bits.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
   localparam logic [7:0] CMD_ERASE_CONF  = 8'hD0;
   localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
   localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
   localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;

   localparam logic [2:0] RES_OK   = 3'd0;
   localparam logic [2:0] RES_VOLT = 3'd1;
   localparam logic [2:0] RES_LOCK = 3'd2;
   localparam logic [2:0] RES_SEQ  = 3'd3;
   localparam logic [2:0] RES_FAIL = 3'd4;
   localparam logic [2:0] RES_TIME = 3'd5;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_SETUP, SQ_CONF, SQ_POLL, SQ_CLR, SQ_EXIT
   } sq_state_t;

   typedef enum logic [1:0] {
      BC_IDLE, BC_STROBE, BC_RECOV
   } bc_state_t;

endpackage

// File: rtl/fseq_bus.sv
module fseq_bus
   import fseq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int STB_W  = 2,
   parameter int REC_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic              ack_o,
   output logic [7:0]        rdata_o,
   output logic              ce_n_o,
   output logic              we_n_o,
   output logic              oe_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [7:0]        dq_o,
   output logic              dq_oe_o,
   input  logic [7:0]        dq_i
);
   localparam int MAXW = (STB_W > REC_W) ? STB_W : REC_W;
   localparam int CW   = $clog2(MAXW + 1);

   bc_state_t   bs;
   logic [CW-1:0] cnt;
   logic        rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bs      <= BC_IDLE;
         cnt     <= '0;
         rd_q    <= 1'b0;
         ack_o   <= 1'b0;
         rdata_o <= '0;
         ce_n_o  <= 1'b1;
         we_n_o  <= 1'b1;
         oe_n_o  <= 1'b1;
         addr_o  <= '0;
         dq_o    <= '0;
      end else begin
         ack_o <= 1'b0;
         case (bs)
            BC_IDLE: if (req_i) begin
               addr_o <= addr_i;
               dq_o   <= wdata_i;
               rd_q   <= rd_i;
               ce_n_o <= 1'b0;
               we_n_o <= rd_i;
               oe_n_o <= !rd_i;
               cnt    <= '0;
               bs     <= BC_STROBE;
            end
            BC_STROBE: if (cnt == CW'(STB_W - 1)) begin
               ce_n_o <= 1'b1;
               we_n_o <= 1'b1;
               oe_n_o <= 1'b1;
               if (rd_q) rdata_o <= dq_i;
               cnt    <= '0;
               bs     <= BC_RECOV;
            end else begin
               cnt <= cnt + 1'b1;
            end
            BC_RECOV: if (cnt == CW'(REC_W - 1)) begin
               ack_o <= 1'b1;
               bs    <= BC_IDLE;
            end else begin
               cnt <= cnt + 1'b1;
            end
            default: bs <= BC_IDLE;
         endcase
      end
   end

   assign dq_oe_o = (bs != BC_IDLE) && !rd_q;

endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
   parameter int LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expired_o
);
   localparam int TW = $clog2(LIMIT + 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (!run_i)                cnt <= '0;
      else if (cnt != TW'(LIMIT))     cnt <= cnt + 1'b1;
   end

   assign expired_o = (cnt == TW'(LIMIT));

endmodule

// File: rtl/fseq_classify.sv
module fseq_classify
   import fseq_pkg::*;
(
   input  logic       erase_i,
   input  logic [7:0] stat_i,
   output logic [2:0] res_o
);
   logic unused_stat;
   assign unused_stat = ^{stat_i[7], stat_i[6], stat_i[2], stat_i[0]};

   always_comb begin
      if (stat_i[3])                    res_o = RES_VOLT;
      else if (stat_i[1])               res_o = RES_LOCK;
      else if (stat_i[4] && stat_i[5])  res_o = RES_SEQ;
      else if (erase_i ? stat_i[5] : stat_i[4]) res_o = RES_FAIL;
      else                              res_o = RES_OK;
   end

endmodule

// File: rtl/flash_job_sequencer.sv
module flash_job_sequencer
   import fseq_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int STB_W   = 2,
   parameter int REC_W   = 2,
   parameter int TIMEOUT = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              job_erase_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [2:0]        result_o,
   output logic              fl_ce_n_o,
   output logic              fl_we_n_o,
   output logic              fl_oe_n_o,
   output logic [ADDR_W-1:0] fl_addr_o,
   output logic [7:0]        fl_dq_o,
   output logic              fl_dq_oe_o,
   input  logic [7:0]        fl_dq_i
);
   initial begin
      assert (ADDR_W >= 1)  else $error("ADDR_W must be positive");
      assert (STB_W >= 1)   else $error("STB_W must be at least 1");
      assert (REC_W >= 1)   else $error("REC_W must be at least 1");
      assert (TIMEOUT >= 1) else $error("TIMEOUT must be at least 1");
   end

   sq_state_t         st;
   logic              pend, req, rd;
   logic [7:0]        wd;
   logic [ADDR_W-1:0] job_addr;
   logic [7:0]        job_data;
   logic              job_er;
   logic              ack, tmo;
   logic [7:0]        rdata;
   logic [2:0]        cls_res;

   fseq_bus #(.ADDR_W(ADDR_W), .STB_W(STB_W), .REC_W(REC_W)) u_bus (
      .clk(clk), .rst_n(rst_n), .req_i(req), .rd_i(rd), .addr_i(job_addr),
      .wdata_i(wd), .ack_o(ack), .rdata_o(rdata), .ce_n_o(fl_ce_n_o),
      .we_n_o(fl_we_n_o), .oe_n_o(fl_oe_n_o), .addr_o(fl_addr_o),
      .dq_o(fl_dq_o), .dq_oe_o(fl_dq_oe_o), .dq_i(fl_dq_i)
   );

   fseq_timer #(.LIMIT(TIMEOUT)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run_i(st == SQ_POLL), .expired_o(tmo)
   );

   fseq_classify u_cls (.erase_i(job_er), .stat_i(rdata), .res_o(cls_res));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         pend     <= 1'b0;
         req      <= 1'b0;
         rd       <= 1'b0;
         wd       <= '0;
         job_addr <= '0;
         job_data <= '0;
         job_er   <= 1'b0;
         result_o <= RES_OK;
         done_o   <= 1'b0;
      end else begin
         req    <= 1'b0;
         done_o <= 1'b0;
         case (st)
            SQ_IDLE: if (start_i) begin
               job_addr <= addr_i;
               job_data <= data_i;
               job_er   <= job_erase_i;
               pend     <= 1'b0;
               st       <= SQ_SETUP;
            end
            SQ_SETUP: begin
               if (!pend) begin
                  req <= 1'b1; pend <= 1'b1; rd <= 1'b0;
                  wd  <= job_er ? CMD_ERASE_SETUP : CMD_PROG_SETUP;
               end
               if (ack) begin pend <= 1'b0; st <= SQ_CONF; end
            end
            SQ_CONF: begin
               if (!pend) begin
                  req <= 1'b1; pend <= 1'b1; rd <= 1'b0;
                  wd  <= job_er ? CMD_ERASE_CONF : job_data;
               end
               if (ack) begin pend <= 1'b0; st <= SQ_POLL; end
            end
            SQ_POLL: begin
               if (!pend) begin
                  if (tmo) begin
                     result_o <= RES_TIME;
                     st       <= SQ_CLR;
                  end else begin
                     req <= 1'b1; pend <= 1'b1; rd <= 1'b1;
                  end
               end
               if (ack) begin
                  pend <= 1'b0;
                  if (rdata[7]) begin
                     result_o <= cls_res;
                     st       <= (cls_res != RES_OK) ? SQ_CLR : SQ_EXIT;
                  end
               end
            end
            SQ_CLR: begin
               if (!pend) begin
                  req <= 1'b1; pend <= 1'b1; rd <= 1'b0; wd <= CMD_CLR_STATUS;
               end
               if (ack) begin pend <= 1'b0; st <= SQ_EXIT; end
            end
            SQ_EXIT: begin
               if (!pend) begin
                  req <= 1'b1; pend <= 1'b1; rd <= 1'b0; wd <= CMD_READ_ARRAY;
               end
               if (ack) begin
                  pend   <= 1'b0;
                  done_o <= 1'b1;
                  st     <= SQ_IDLE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign busy_o = (st != SQ_IDLE);

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
   parameter int ADDR_W = 20,
   parameter int STB_W  = 2,
   parameter int REC_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              we_n,
   input logic              oe_n,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        dq,
   input logic              dq_oe,
   input logic              done,
   input logic              busy,
   input logic [2:0]        result
);
   localparam int CW = $clog2(STB_W + REC_W + 2);

   logic          act;
   logic [CW-1:0] lo_cnt, hi_cnt;

   assign act = !we_n || !oe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_cnt <= CW'(REC_W);
      end else if (act) begin
         lo_cnt <= (lo_cnt == {CW{1'b1}}) ? lo_cnt : lo_cnt + 1'b1;
         hi_cnt <= '0;
      end else begin
         lo_cnt <= '0;
         hi_cnt <= (hi_cnt >= CW'(REC_W)) ? hi_cnt : hi_cnt + 1'b1;
      end
   end

   // R3
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !oe_n));
   // R3
   select_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> !ce_n);
   // R3
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!act && lo_cnt != '0) |-> (lo_cnt == CW'(STB_W)));
   // R3
   recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && lo_cnt == '0) |-> (hi_cnt >= CW'(REC_W)));
   // R4
   write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> ($stable(addr) && $stable(dq) && dq_oe));
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R6
   result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (result <= 3'd5));

endmodule

bind flash_job_sequencer fseq_chk #(.ADDR_W(ADDR_W), .STB_W(STB_W), .REC_W(REC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(fl_ce_n_o), .we_n(fl_we_n_o), .oe_n(fl_oe_n_o),
   .addr(fl_addr_o), .dq(fl_dq_o), .dq_oe(fl_dq_oe_o), .done(done_o),
   .busy(busy_o), .result(result_o)
);

// File: tb/flash_job_sequencer_test.sv
module flash_job_sequencer_test;
   localparam int AW  = 20;
   localparam int TMO = 200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, er = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    data = '0;
   logic          busy, done, ce_n, we_n, oe_n, dq_oe;
   logic [2:0]    result;
   logic [AW-1:0] fa;
   logic [7:0]    fdo, fdi;

   always #4 clk = ~clk;

   flash_job_sequencer #(.ADDR_W(AW), .STB_W(2), .REC_W(2), .TIMEOUT(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .job_erase_i(er), .addr_i(addr),
      .data_i(data), .busy_o(busy), .done_o(done), .result_o(result),
      .fl_ce_n_o(ce_n), .fl_we_n_o(we_n), .fl_oe_n_o(oe_n), .fl_addr_o(fa),
      .fl_dq_o(fdo), .fl_dq_oe_o(dq_oe), .fl_dq_i(fdi)
   );

   int checks = 0, errors = 0;
   bit ended = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // behavioural flash model
   logic [7:0] sr = 8'h80, sr_latch = 8'h80;
   int  bcnt = 0, dur = 20, reads = 0, done_cnt = 0;
   logic [7:0] inj = 8'h00;
   int  phase = 0;
   logic pwe = 1'b1, poe = 1'b1;
   assign fdi = sr_latch;

   // scoreboard queues
   logic [AW+7:0] exp_wr[$];
   logic [2:0]    exp_res[$];

   always @(negedge clk) begin
      if (bcnt > 0) begin
         bcnt = bcnt - 1;
         if (bcnt == 0) sr = 8'h80 | inj;
      end
      if (poe && !oe_n) begin
         sr_latch = sr;
         reads++;
      end
      if (!pwe && we_n) begin
         if (exp_wr.size() == 0) chk(0, "R2 unexpected write", {fa, fdo}, 0);
         else begin
            logic [AW+7:0] e;
            e = exp_wr.pop_front();
            chk({fa, fdo} == e, "R2/R7/R8/R10 write order", {fa, fdo}, e);
         end
         if (bcnt == 0) begin
            if (phase == 1 && fdo == 8'hD0) begin bcnt = dur; sr = 8'h00; phase = 0; end
            else if (phase == 2) begin bcnt = dur; sr = 8'h00; phase = 0; end
            else if (fdo == 8'h20) phase = 1;
            else if (fdo == 8'h40) phase = 2;
            else if (fdo == 8'h50) sr[5:1] = 5'd0;
         end
      end
      if (done) begin
         done_cnt++;
         if (exp_res.size() == 0) chk(0, "R8 unexpected done", result, 0);
         else begin
            logic [2:0] r;
            r = exp_res.pop_front();
            chk(result == r, "R6/R9 result", result, r);
         end
      end
      pwe = we_n;
      poe = oe_n;
   end

   task automatic run_job(input bit e, input logic [AW-1:0] a, input logic [7:0] d,
                          input int t, input logic [7:0] inject, input logic [2:0] r);
      int start_done;
      exp_wr.push_back({a, e ? 8'h20 : 8'h40});
      exp_wr.push_back({a, e ? 8'hD0 : d});
      if (r != 3'd0) exp_wr.push_back({a, 8'h50});
      exp_wr.push_back({a, 8'hFF});
      exp_res.push_back(r);
      dur = t; inj = inject; reads = 0;
      start_done = done_cnt;
      @(negedge clk);
      er = e; addr = a; data = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (done_cnt == start_done) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      summary();
   end

   initial begin : main
      int t0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ce_n && we_n && oe_n, "R1 strobes in reset", {ce_n, we_n, oe_n}, 3'b111);
      chk(!busy && !done && result == 0, "R1 status in reset", {busy, done, result}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ce_n && we_n && oe_n, "R1 strobes after reset", {ce_n, we_n, oe_n}, 3'b111);
      chk(!busy && !done && result == 0, "R1 status after reset", {busy, done, result}, 0);

      // R2 R5 erase success with several polls
      run_job(1, 20'h3_4567, 8'h00, 60, 8'h00, 3'd0);
      chk(reads >= 2, "R5 repeated polls", reads, 2);
      // R8 result held after done
      repeat (10) @(negedge clk);
      chk(result == 3'd0 && !done, "R8 result held", result, 0);
      // R2 program success
      run_job(0, 20'hA_BCDE, 8'hA5, 12, 8'h00, 3'd0);
      // R6 failure codes
      run_job(1, 20'h1_0000, 8'h00, 8, 8'h20, 3'd4);
      run_job(0, 20'h0_0042, 8'h3C, 8, 8'h10, 3'd4);
      run_job(1, 20'h2_0001, 8'h00, 8, 8'h10, 3'd0);   // R6 bit 4 alone on erase
      run_job(0, 20'h2_0002, 8'h11, 8, 8'h20, 3'd0);   // R6 bit 5 alone on program
      run_job(1, 20'h5_5555, 8'h00, 8, 8'h30, 3'd3);   // R6 sequence
      run_job(0, 20'h6_0006, 8'h77, 8, 8'h3A, 3'd1);   // R6 voltage first; R7
      run_job(1, 20'h7_0007, 8'h00, 8, 8'h22, 3'd2);   // R6 lock over failure
      // R9 timeout
      t0 = 0;
      fork
         run_job(1, 20'hF_0000, 8'h00, 100000, 8'h00, 3'd5);
         begin while (!done) begin @(negedge clk); t0++; end end
      join
      chk(t0 >= TMO, "R9 timeout window", t0, TMO);
      bcnt = 0; sr = 8'h80; phase = 0;
      // R10 start while busy is ignored
      exp_wr.push_back({20'h0_1111, 8'h40});
      exp_wr.push_back({20'h0_1111, 8'h5A});
      exp_wr.push_back({20'h0_1111, 8'hFF});
      exp_res.push_back(3'd0);
      dur = 30; inj = 8'h00;
      t0 = done_cnt;
      @(negedge clk); er = 0; addr = 20'h0_1111; data = 8'h5A; start = 1;
      @(negedge clk); start = 0;
      repeat (5) @(negedge clk);
      er = 1; addr = 20'h9_9999; start = 1;
      @(negedge clk); start = 0;
      while (done_cnt == t0) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(exp_wr.size() == 0 && !busy, "R10 no extra job", exp_wr.size(), 0);
      chk(done_cnt == t0 + 1, "R10 single done", done_cnt, t0 + 1);
      summary();
   end

endmodule